// File: doc/BRIEF.md
# Video Timing Reference Decoder

This block watches an 8-bit multiplexed 4:2:2 YCbCr video stream, one word per rising edge of the video clock (27 MHz nominal). It searches the stream for the in-band timing references that mark where active video ends and begins on each line. Each reference is a three-word preamble, one all-ones word and two all-zeros words, followed by a status word. The status word carries the field, vertical-blank and horizontal-blank flags together with four protection bits.

The block checks the status word and repairs any single-bit error in it. It then drives `hsync`, `vsync` and `field` from the flags of the last code it accepted. No external sync or blanking input is used. The behaviour is the same for 525-line and 625-line systems. Words that follow a start-of-active code outside vertical blanking are passed out with a component tag. A code with an error that cannot be repaired leaves the flags unchanged and raises a saturating error count.

Top module: `vid_timing_dec`

## Requirements
- R1: A synchronous active-high `rst` puts the outputs in blanking: `hsync`=1, `vsync`=1, `field`=0. It also clears `act_valid`, `code_ok`, `code_fix` and `err_cnt` to 0. The outputs stay in that state until the first code is accepted.
- R2: A code is the word sequence 0xFF, 0x00, 0x00, XY on consecutive clock edges. When XY is accepted, the flags change on the edge that captures XY, and `code_ok` is high for exactly the following cycle. If the preamble is broken by any other word, nothing is decoded.
- R3: XY has this layout. Bit 7 is 1, bit 6 is F, bit 5 is V, bit 4 is H. Bits 3..0 hold P3..P0, where P3=V^H, P2=F^H, P1=F^V and P0=F^V^H. After acceptance, `field`=F, `vsync`=V and `hsync`=H; H=1 marks end of active video and H=0 marks start of active video.
- R4: A single flipped bit anywhere in XY (bits 7..0) is corrected. The code is accepted with the corrected flags, and `code_fix` pulses in the same cycle as `code_ok`.
- R5: Some XY words cannot be decoded: any two-bit error, and any syndrome that matches no single bit. For such a word, `hsync`/`vsync`/`field` keep their previous values, `code_ok` stays 0, no active run starts, and `err_cnt` rises by one.
- R6: `err_cnt` saturates at 2^ERR_W-1 and never wraps.
- R7: After an accepted code with H=0 and V=0, each following word appears on `act_data` with `act_valid`=1 one cycle after it is captured. Its tag on `act_comp` repeats the order Cb=0, Y=1, Cr=2, Y=3, and every run starts at Cb.
- R8: An active run ends on the edge that captures an 0xFF word, and that word is not tagged. An accepted start code with V=1 starts no run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video word clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vid_in | input | 8 | Multiplexed video word |
| hsync | output | 1 | H flag of the last accepted code |
| vsync | output | 1 | V flag of the last accepted code |
| field | output | 1 | F flag of the last accepted code |
| act_valid | output | 1 | Active sample present on act_data |
| act_comp | output | 2 | Component tag: 0 Cb, 1 Y, 2 Cr, 3 Y |
| act_data | output | 8 | Active sample word |
| code_ok | output | 1 | One-cycle pulse per accepted code |
| code_fix | output | 1 | Pulse when the accepted code needed a one-bit repair |
| err_cnt | output | ERR_W | Saturating count of codes that could not be decoded |

## Verification
The hardest condition to reach from the ports is saturation of the error count. It needs hundreds of complete codes that cannot be decoded, each behind a clean preamble, while no decodable code slips in between. The stimulus drives a long loop of preambles that each end in a two-bit-damaged status word, and checks the count at its ceiling and again after one more bad code. Single-bit repair is driven separately for a flag bit, a protection bit and bit 7. A start code damaged in one flag bit must still open a correctly tagged active run.

// File: rtl/vtd_pkg.sv
package vtd_pkg;

    localparam int WORD_W = 8;
    localparam logic [WORD_W-1:0] WORD_ONES  = '1;
    localparam logic [WORD_W-1:0] WORD_ZEROS = '0;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } vtd_flags_t;

    localparam vtd_flags_t FLAGS_BLANK = '{f: 1'b0, v: 1'b1, h: 1'b1};

    typedef struct packed {
        logic       ok;
        logic       fixed;
        vtd_flags_t flg;
    } vtd_xy_t;

    typedef enum logic [1:0] {
        COMP_CB = 2'd0,
        COMP_YA = 2'd1,
        COMP_CR = 2'd2,
        COMP_YB = 2'd3
    } vtd_comp_t;

    // Syndrome seen when exactly one flag bit is flipped
    localparam logic [3:0] SYN_F = 4'b0111;
    localparam logic [3:0] SYN_V = 4'b1011;
    localparam logic [3:0] SYN_H = 4'b1101;

    function automatic logic [3:0] prot_bits(input vtd_flags_t fl);
        return {fl.v ^ fl.h, fl.f ^ fl.h, fl.f ^ fl.v, fl.f ^ fl.v ^ fl.h};
    endfunction

    function automatic vtd_xy_t xy_decode(input logic [WORD_W-1:0] w);
        vtd_xy_t    r;
        vtd_flags_t fl;
        logic [3:0] syn;
        fl.f    = w[6];
        fl.v    = w[5];
        fl.h    = w[4];
        syn     = w[3:0] ^ prot_bits(fl);
        r.flg   = fl;
        r.ok    = 1'b0;
        r.fixed = 1'b0;
        if (syn == 4'b0000) begin
            // clean, or only the fixed top bit was hit
            r.ok    = 1'b1;
            r.fixed = ~w[7];
        end else if (w[7]) begin
            if ((syn & (syn - 4'd1)) == 4'b0000) begin
                // one protection bit flipped
                r.ok    = 1'b1;
                r.fixed = 1'b1;
            end else begin
                case (syn)
                    SYN_F: begin r.ok = 1'b1; r.fixed = 1'b1; r.flg.f = ~fl.f; end
                    SYN_V: begin r.ok = 1'b1; r.fixed = 1'b1; r.flg.v = ~fl.v; end
                    SYN_H: begin r.ok = 1'b1; r.fixed = 1'b1; r.flg.h = ~fl.h; end
                    default: r.ok = 1'b0;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/vtd_preamble.sv
module vtd_preamble
    import vtd_pkg::*;
#(
    parameter int PRE_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] din,
    output logic              hit
);

    // hist[0] is the newest word, hist[PRE_LEN-1] the oldest
    logic [PRE_LEN-1:0][WORD_W-1:0] hist;
    logic [PRE_LEN-1:0]             stage_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {hist[PRE_LEN-2:0], din};
        end
    end

    for (genvar g = 0; g < PRE_LEN; g++) begin : g_stage
        if (g == PRE_LEN - 1) begin : g_lead
            assign stage_ok[g] = (hist[g] == WORD_ONES);
        end else begin : g_zero
            assign stage_ok[g] = (hist[g] == WORD_ZEROS);
        end
    end

    // din is the status word when the history holds the preamble
    assign hit = &stage_ok;

endmodule

// File: rtl/vtd_flag_track.sv
module vtd_flag_track
    import vtd_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  vtd_xy_t          xy,
    output vtd_flags_t       flg,
    output logic             code_ok,
    output logic             code_fix,
    output logic [ERR_W-1:0] err_cnt
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic accept;
    logic reject;

    assign accept = hit && xy.ok;
    assign reject = hit && !xy.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            flg      <= FLAGS_BLANK;
            code_ok  <= 1'b0;
            code_fix <= 1'b0;
            err_cnt  <= '0;
        end else begin
            code_ok  <= accept;
            code_fix <= accept && xy.fixed;
            if (accept) begin
                flg <= xy.flg;
            end
            if (reject && (err_cnt != ERR_MAX)) begin
                err_cnt <= err_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vtd_tagger.sv
module vtd_tagger
    import vtd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_start,
    input  logic [WORD_W-1:0] din,
    output logic              act_valid,
    output logic [1:0]        act_comp,
    output logic [WORD_W-1:0] act_data
);

    logic      in_run;
    vtd_comp_t phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_run    <= 1'b0;
            phase     <= COMP_CB;
            act_valid <= 1'b0;
            act_comp  <= 2'd0;
            act_data  <= '0;
        end else if (run_start) begin
            in_run    <= 1'b1;
            phase     <= COMP_CB;
            act_valid <= 1'b0;
        end else if (in_run && (din == WORD_ONES)) begin
            in_run    <= 1'b0;
            act_valid <= 1'b0;
        end else if (in_run) begin
            act_valid <= 1'b1;
            act_data  <= din;
            act_comp  <= phase;
            phase     <= vtd_comp_t'(phase + 2'd1);
        end else begin
            act_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/vid_timing_dec.sv
module vid_timing_dec
    import vtd_pkg::*;
#(
    parameter int ERR_W   = 8,
    parameter int PRE_LEN = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       vid_in,
    output logic             hsync,
    output logic             vsync,
    output logic             field,
    output logic             act_valid,
    output logic [1:0]       act_comp,
    output logic [7:0]       act_data,
    output logic             code_ok,
    output logic             code_fix,
    output logic [ERR_W-1:0] err_cnt
);

    logic       pre_hit;
    vtd_xy_t    xy_now;
    vtd_flags_t flg_q;
    logic       run_start;

    vtd_preamble #(.PRE_LEN(PRE_LEN)) u_pre (
        .clk (clk),
        .rst (rst),
        .din (vid_in),
        .hit (pre_hit)
    );

    assign xy_now = xy_decode(vid_in);

    vtd_flag_track #(.ERR_W(ERR_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .hit      (pre_hit),
        .xy       (xy_now),
        .flg      (flg_q),
        .code_ok  (code_ok),
        .code_fix (code_fix),
        .err_cnt  (err_cnt)
    );

    assign run_start = pre_hit && xy_now.ok && !xy_now.flg.h && !xy_now.flg.v;

    vtd_tagger u_tag (
        .clk       (clk),
        .rst       (rst),
        .run_start (run_start),
        .din       (vid_in),
        .act_valid (act_valid),
        .act_comp  (act_comp),
        .act_data  (act_data)
    );

    assign hsync = flg_q.h;
    assign vsync = flg_q.v;
    assign field = flg_q.f;

endmodule

// File: rtl/vtd_checker.sv
module vtd_checker #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             hsync,
    input logic             vsync,
    input logic             field,
    input logic             act_valid,
    input logic [1:0]       act_comp,
    input logic             code_ok,
    input logic             code_fix,
    input logic [ERR_W-1:0] err_cnt
);

    localparam logic [ERR_W-1:0] CNT_TOP = '1;

    p_reset_blank_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hsync && vsync && !field && !act_valid && !code_ok && err_cnt == '0));

    p_ok_single_r2: assert property (@(posedge clk) disable iff (rst)
        code_ok |=> !code_ok);

    p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !code_ok) |-> $stable({hsync, vsync, field}));

    p_fix_with_ok_r4: assert property (@(posedge clk) disable iff (rst)
        code_fix |-> code_ok);

    p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + 1'b1));

    p_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(err_cnt) == CNT_TOP) |-> (err_cnt == CNT_TOP));

    p_act_open_r7: assert property (@(posedge clk) disable iff (rst)
        act_valid |-> (!hsync && !vsync));

    p_comp_order_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && act_valid && $past(act_valid)) |-> (act_comp == $past(act_comp) + 2'd1));

    p_run_first_cb_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && act_valid && !$past(act_valid)) |-> (act_comp == 2'd0));

endmodule

bind vid_timing_dec vtd_checker #(.ERR_W(ERR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hsync     (hsync),
    .vsync     (vsync),
    .field     (field),
    .act_valid (act_valid),
    .act_comp  (act_comp),
    .code_ok   (code_ok),
    .code_fix  (code_fix),
    .err_cnt   (err_cnt)
);

// File: tb/sim_vid_timing_dec.sv
module sim_vid_timing_dec;

    localparam int EW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    vid_in;
    logic          hsync, vsync, field;
    logic          act_valid;
    logic [1:0]    act_comp;
    logic [7:0]    act_data;
    logic          code_ok, code_fix;
    logic [EW-1:0] err_cnt;

    int n_chk = 0;
    int n_err = 0;
    int exp_phase = 0;
    bit done = 0;

    typedef struct {
        logic [1:0] comp;
        logic [7:0] data;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    vid_timing_dec #(.ERR_W(EW)) u0 (
        .clk(clk), .rst(rst), .vid_in(vid_in),
        .hsync(hsync), .vsync(vsync), .field(field),
        .act_valid(act_valid), .act_comp(act_comp), .act_data(act_data),
        .code_ok(code_ok), .code_fix(code_fix), .err_cnt(err_cnt)
    );

    function automatic logic [7:0] mk_xy(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one word; on return the outputs reflect the previous word
    task automatic send(input logic [7:0] w);
        @(negedge clk);
        vid_in = w;
    endtask

    // drive one active word and record what the monitor should see
    task automatic send_act(input logic [7:0] w);
        item_t it;
        @(negedge clk);
        vid_in = w;
        it.comp = 2'(exp_phase);
        it.data = w;
        sb.push_back(it);
        exp_phase = (exp_phase + 1) % 4;
    endtask

    task automatic code(input logic [7:0] xy);
        send(8'hFF);
        send(8'h00);
        send(8'h00);
        send(xy);
    endtask

    task automatic chk_flags(input string req, input bit h, input bit v, input bit f);
        chk(req, "hsync", int'(hsync), int'(h));
        chk(req, "vsync", int'(vsync), int'(v));
        chk(req, "field", int'(field), int'(f));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && act_valid) begin
            if (sb.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL R8 untagged word seen: actual=%0h expected=none", act_data);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk("R7", "act_comp", int'(act_comp), int'(it.comp));
                chk("R7", "act_data", int'(act_data), int'(it.data));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        vid_in = 8'h10;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, held while no code has arrived
        send(8'h10);
        send(8'h10);
        chk_flags("R1", 1, 1, 0);
        chk("R1", "act_valid", int'(act_valid), 0);
        chk("R1", "err_cnt", int'(err_cnt), 0);
        chk("R1", "code_ok", int'(code_ok), 0);
        chk("R1", "code_fix", int'(code_fix), 0);

        // R2/R3: end-of-active code, field 0
        code(mk_xy(0, 0, 1));
        send(8'h10);
        chk("R2", "code_ok", int'(code_ok), 1);
        chk("R2", "code_fix", int'(code_fix), 0);
        chk_flags("R3", 1, 0, 0);
        send(8'h10);
        chk("R2", "code_ok pulse end", int'(code_ok), 0);

        // R7: start code opens a tagged run
        code(mk_xy(0, 0, 0));
        exp_phase = 0;
        send_act(8'h21);
        chk_flags("R3", 0, 0, 0);
        for (int i = 0; i < 7; i++) send_act(8'h22 + 8'(i));
        // R8: 0xFF closes the run
        code(mk_xy(0, 0, 1));
        send(8'h10);
        chk_flags("R3", 1, 0, 0);
        chk("R8", "act_valid after close", int'(act_valid), 0);

        // R8: start code inside vertical blanking tags nothing
        code(mk_xy(0, 1, 0));
        send(8'h55);
        chk_flags("R3", 0, 1, 0);
        send(8'h56);
        chk("R8", "act_valid in vblank", int'(act_valid), 0);
        send(8'h57);
        chk("R8", "act_valid in vblank", int'(act_valid), 0);

        // R3: field 1
        code(mk_xy(1, 0, 1));
        send(8'h10);
        chk_flags("R3", 1, 0, 1);

        // R4: flipped F bit on a start code
        code(mk_xy(1, 0, 0) ^ 8'h40);
        exp_phase = 0;
        send_act(8'h30);
        chk("R4", "code_ok", int'(code_ok), 1);
        chk("R4", "code_fix", int'(code_fix), 1);
        chk_flags("R4", 0, 0, 1);
        for (int i = 1; i < 6; i++) send_act(8'h30 + 8'(i));
        // R4: flipped protection bit
        code(mk_xy(1, 0, 1) ^ 8'h01);
        send(8'h10);
        chk("R4", "code_fix parity", int'(code_fix), 1);
        chk_flags("R4", 1, 0, 1);
        // R4: flipped top bit
        code(mk_xy(0, 0, 1) ^ 8'h80);
        send(8'h10);
        chk("R4", "code_fix top bit", int'(code_fix), 1);
        chk_flags("R4", 1, 0, 0);
        // R4: flipped H bit
        code(mk_xy(1, 1, 1) ^ 8'h10);
        send(8'h10);
        chk("R4", "code_fix H bit", int'(code_fix), 1);
        chk_flags("R4", 1, 1, 1);

        // R5: two-bit errors hold the flags
        code(mk_xy(0, 0, 0) ^ 8'h03);
        send(8'h10);
        chk("R5", "code_ok", int'(code_ok), 0);
        chk_flags("R5", 1, 1, 1);
        chk("R5", "err_cnt", int'(err_cnt), 1);
        code(8'h01);
        send(8'h10);
        chk("R5", "err_cnt top bit clear", int'(err_cnt), 2);
        chk_flags("R5", 1, 1, 1);
        code(mk_xy(0, 0, 0) ^ 8'h30);
        send(8'h60);
        send(8'h61);
        chk("R5", "no run from bad code", int'(act_valid), 0);
        chk("R5", "err_cnt", int'(err_cnt), 3);

        // R2: broken preamble decodes nothing
        send(8'hFF);
        send(8'h00);
        send(8'h11);
        send(mk_xy(0, 0, 0));
        send(8'h10);
        chk("R2", "code_ok broken", int'(code_ok), 0);
        chk_flags("R2", 1, 1, 1);

        // R6: saturation
        for (int i = 0; i < 300; i++) code(mk_xy(0, 0, 0) ^ 8'h03);
        send(8'h10);
        chk("R6", "err_cnt saturated", int'(err_cnt), 255);
        code(mk_xy(0, 0, 0) ^ 8'h03);
        send(8'h10);
        chk("R6", "err_cnt stays", int'(err_cnt), 255);

        // R1: reset returns to blanking
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_flags("R1", 1, 1, 0);
        chk("R1", "err_cnt after reset", int'(err_cnt), 0);

        // R7: a fresh run after reset starts at Cb again
        code(mk_xy(0, 0, 0));
        exp_phase = 0;
        for (int i = 0; i < 5; i++) send_act(8'h70 + 8'(i));
        send(8'hFF);
        send(8'h00);
        send(8'h10);
        send(8'h10);
        chk("R7", "scoreboard drained", sb.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule